// File: doc/BRIEF.md
# Cache Access Blocking Controller

This block decides when the request side of a cache must turn new requests away because one of its two resource queues has run out of entries. The queues are the miss-status holding queue and the write buffer. Each reports a full level together with one-cycle strobes for an allocation and for an entry being marked in service. The controller keeps one blocking bit per queue and drives a registered ready signal to the upstream requester. After a refusal, it issues a single retry pulse once every blocking bit has cleared.

A cause becomes active when an allocation leaves its queue full. It is released only when an entry is marked in service and that moves the queue from full to not full. A queue that simply reads not full is not enough to release it. For each cause the block also counts how many times blocking began and adds up how many cycles the cause stayed active. Both counters saturate.

Top module: `cache_block_ctrl`

## Requirements
- R1: After a synchronous reset, block_mask is 0, req_ready is 1, req_retry is 0 and every event and cycle counter reads 0.
- R2: A cycle with q_alloc[c] and q_full[c] both high sets block_mask[c] at the next edge. Bit 0 is the miss-status queue and bit 1 is the write buffer. An allocation with full low does not set the bit, and neither does full without an allocation.
- R3: block_mask[c] clears only at an edge where q_issue[c] is high, q_full[c] is low, and q_full[c] was high in the previous cycle. A full level that falls without an issue strobe, or an issue strobe whose previous full level was low, leaves the bit set.
- R4: req_ready is high exactly when block_mask is zero, and it changes at the same edge as the mask.
- R5: An allocation that finds its queue full while that cause is already set changes neither the mask nor that cause's event counter.
- R6: Each transition of block_mask[c] from 0 to 1 increments event counter c, held in block_events[c*EVT_W +: EVT_W]. The counter never decreases and stops at 2^EVT_W-1.
- R7: When block_mask[c] clears, counter c in block_cycles[c*ACC_W +: ACC_W] grows by the number of clock edges from the setting edge to the clearing edge, saturating at 2^ACC_W-1.
- R8: If req_valid was high while req_ready was low at any edge since the last retry, req_retry is high for exactly one cycle. That cycle starts at the edge where the mask becomes zero, and req_ready is high during it.
- R9: If no request was refused, clearing the mask raises no retry.
- R10: While one cause stays set, clearing the other keeps req_ready low and raises no retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| q_alloc | input | 2 | Allocation strobe per queue (bit 0 miss-status, bit 1 write buffer) |
| q_full | input | 2 | Full level per queue, reflecting this cycle's strobes |
| q_issue | input | 2 | Mark-in-service strobe per queue |
| req_valid | input | 1 | Upstream requester is presenting a request |
| req_ready | output | 1 | Requests are accepted |
| req_retry | output | 1 | One-cycle retry pulse to a refused requester |
| block_mask | output | 2 | Active blocking causes |
| block_events | output | 2*EVT_W | Per-cause count of blocking starts, cause 0 in the low slice |
| block_cycles | output | 2*ACC_W | Per-cause accumulated blocked cycles, cause 0 in the low slice |

## Verification
The assertions assume that q_full reports the queue state after the same cycle's strobes. They also assume that an allocation and an in-service strobe that would both act on one queue never arrive in the same cycle. The bench respects both assumptions: it raises full together with the allocation that fills a queue, and it lowers full together with the issue strobe that frees an entry. It keeps each blocked interval much shorter than the timestamp wrap so that elapsed-cycle differences stay exact.

// File: rtl/cache_block_ctrl.sv
module cache_block_ctrl #(
  parameter int EVT_W = 4,
  parameter int ACC_W = 8,
  parameter int TS_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           q_alloc,
  input  logic [1:0]           q_full,
  input  logic [1:0]           q_issue,
  input  logic                 req_valid,
  output logic                 req_ready,
  output logic                 req_retry,
  output logic [1:0]           block_mask,
  output logic [2*EVT_W-1:0]   block_events,
  output logic [2*ACC_W-1:0]   block_cycles
);

  localparam int NC = 2;
  localparam int SW = ((ACC_W > TS_W) ? ACC_W : TS_W) + 1;
  localparam logic [EVT_W-1:0] EVT_MAX = '1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [TS_W-1:0] now_q;
  logic [NC-1:0]   mask_q, mask_d, full_q, set_c, clr_c;
  logic            ready_q, retry_q, pend_q, pend_n, refuse, fire;

  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_cause
      logic [TS_W-1:0]  start_q;
      logic [EVT_W-1:0] evt_q;
      logic [ACC_W-1:0] acc_q;
      logic [TS_W-1:0]  elapsed;
      logic [SW-1:0]    sum;

      assign set_c[c] = q_alloc[c] & q_full[c] & ~mask_q[c];
      assign clr_c[c] = q_issue[c] & full_q[c] & ~q_full[c] & mask_q[c];
      assign elapsed  = now_q - start_q;
      assign sum      = SW'(acc_q) + SW'(elapsed);

      always_ff @(posedge clk) begin
        if (rst) begin
          start_q <= '0;
          evt_q   <= '0;
          acc_q   <= '0;
        end else begin
          if (set_c[c]) begin
            start_q <= now_q;
            if (evt_q != EVT_MAX) evt_q <= evt_q + 1'b1;
          end
          if (clr_c[c])
            acc_q <= (sum > SW'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
        end
      end

      assign block_events[c*EVT_W +: EVT_W] = evt_q;
      assign block_cycles[c*ACC_W +: ACC_W] = acc_q;
    end
  endgenerate

  assign mask_d = (mask_q | set_c) & ~clr_c;
  assign refuse = req_valid & ~ready_q;
  assign pend_n = pend_q | refuse;
  assign fire   = pend_n & ~|mask_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q   <= '0;
      mask_q  <= '0;
      full_q  <= '0;
      ready_q <= 1'b1;
      retry_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      now_q   <= now_q + 1'b1;
      mask_q  <= mask_d;
      full_q  <= q_full;
      ready_q <= ~|mask_d;
      retry_q <= fire;
      pend_q  <= pend_n & ~fire;
    end
  end

  assign req_ready  = ready_q;
  assign req_retry  = retry_q;
  assign block_mask = mask_q;

endmodule

// File: rtl/cache_block_ctrl_chk.sv
module cache_block_ctrl_chk #(
  parameter int EVT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         q_alloc,
  input logic [1:0]         q_full,
  input logic [1:0]         q_issue,
  input logic               req_ready,
  input logic               req_retry,
  input logic [1:0]         block_mask,
  input logic [2*EVT_W-1:0] block_events
);

  // R4
  ready_mask_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready == (block_mask == 2'b00));

  // R8
  retry_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_retry |=> !req_retry);

  // R8
  retry_ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_retry |-> req_ready);

  // R2
  set_mq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(block_mask[0]) |-> $past(q_alloc[0] & q_full[0]));

  // R2
  set_wb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(block_mask[1]) |-> $past(q_alloc[1] & q_full[1]));

  // R3
  clr_mq_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(block_mask[0]) |-> $past(q_issue[0] & ~q_full[0]));

  // R3
  clr_wb_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(block_mask[1]) |-> $past(q_issue[1] & ~q_full[1]));

  // R6
  evt_mono_mq_chk: assert property (@(posedge clk) disable iff (rst)
    block_events[EVT_W-1:0] >= $past(block_events[EVT_W-1:0]));

  // R6
  evt_mono_wb_chk: assert property (@(posedge clk) disable iff (rst)
    block_events[2*EVT_W-1:EVT_W] >= $past(block_events[2*EVT_W-1:EVT_W]));

endmodule

bind cache_block_ctrl cache_block_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst(rst), .q_alloc(q_alloc), .q_full(q_full),
  .q_issue(q_issue), .req_ready(req_ready), .req_retry(req_retry),
  .block_mask(block_mask), .block_events(block_events)
);

// File: tb/cache_block_ctrl_tb.sv
module cache_block_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int EW = 4;
  localparam int AW = 8;
  localparam int EMAX = 15;
  localparam int AMAX = 255;

  logic clk = 0, rst = 1;
  logic [1:0] q_alloc = 0, q_full = 0, q_issue = 0;
  logic req_valid = 0;
  logic req_ready, req_retry;
  logic [1:0] block_mask;
  logic [2*EW-1:0] block_events;
  logic [2*AW-1:0] block_cycles;

  int checks = 0, fails = 0, edges = 0;
  int exp_evt[2], exp_cyc[2], t_set[2];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  cache_block_ctrl #(.EVT_W(EW), .ACC_W(AW), .TS_W(12)) u_dut (
    .clk(clk), .rst(rst), .q_alloc(q_alloc), .q_full(q_full),
    .q_issue(q_issue), .req_valid(req_valid), .req_ready(req_ready),
    .req_retry(req_retry), .block_mask(block_mask),
    .block_events(block_events), .block_cycles(block_cycles));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int evt(input int c);
    return int'(block_events[c*EW +: EW]);
  endfunction

  function automatic int cyc(input int c);
    return int'(block_cycles[c*AW +: AW]);
  endfunction

  task automatic block(input int c);
    q_alloc[c] = 1; q_full[c] = 1;
    step();
    q_alloc[c] = 0;
    t_set[c] = edges;
    exp_evt[c] = (exp_evt[c] < EMAX) ? exp_evt[c] + 1 : EMAX;
  endtask

  task automatic unblock(input int c);
    q_issue[c] = 1; q_full[c] = 0;
    step();
    q_issue[c] = 0;
    exp_cyc[c] = exp_cyc[c] + (edges - t_set[c]);
    if (exp_cyc[c] > AMAX) exp_cyc[c] = AMAX;
  endtask

  task automatic t_reset();
    chk("R1 mask", block_mask, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 retry", req_retry, 0);
    chk("R1 events", block_events, 0);
    chk("R1 cycles", block_cycles, 0);
  endtask

  task automatic t_basic();
    block(0);
    chk("R2 mask after alloc to full", block_mask, 1);
    chk("R4 ready low", req_ready, 0);
    repeat (3) step();
    unblock(0);
    chk("R3 mask cleared", block_mask, 0);
    chk("R4 ready high", req_ready, 1);
    chk("R7 blocked cycles", cyc(0), exp_cyc[0]);
    chk("R7 blocked cycles equals 4", cyc(0), 4);
    chk("R6 event count", evt(0), exp_evt[0]);
    chk("R9 no retry without refusal", req_retry, 0);
  endtask

  task automatic t_no_alloc();
    q_alloc[1] = 1; q_full[1] = 0;
    step();
    q_alloc[1] = 0;
    chk("R2 alloc without full", block_mask, 0);
    q_full[1] = 1;
    step();
    chk("R2 full without alloc", block_mask, 0);
    q_full[1] = 0;
    step();
  endtask

  task automatic t_sticky();
    block(1);
    chk("R2 write buffer bit", block_mask, 2);
    q_full[1] = 0;
    repeat (2) step();
    chk("R3 full fell without issue", block_mask, 2);
    q_issue[1] = 1;
    step();
    q_issue[1] = 0;
    chk("R3 issue while previously not full", block_mask, 2);
    q_full[1] = 1;
    step();
    unblock(1);
    chk("R3 cleared on full to not full", block_mask, 0);
    chk("R7 write buffer cycles", cyc(1), exp_cyc[1]);
    chk("R9 no retry", req_retry, 0);
  endtask

  task automatic t_reblock();
    block(0);
    q_alloc[0] = 1;
    step();
    q_alloc[0] = 0;
    chk("R5 mask unchanged", block_mask, 1);
    chk("R5 events unchanged", evt(0), exp_evt[0]);
    unblock(0);
    chk("R7 cycles after reblock", cyc(0), exp_cyc[0]);
  endtask

  task automatic t_retry();
    block(0);
    req_valid = 1;
    step();
    req_valid = 0;
    repeat (2) step();
    chk("R8 no retry while blocked", req_retry, 0);
    unblock(0);
    chk("R8 retry on unblock", req_retry, 1);
    chk("R8 ready with retry", req_ready, 1);
    step();
    chk("R8 retry one cycle", req_retry, 0);
  endtask

  task automatic t_two();
    block(0);
    block(1);
    chk("R10 both bits", block_mask, 3);
    req_valid = 1;
    step();
    req_valid = 0;
    unblock(0);
    chk("R10 mask keeps other cause", block_mask, 2);
    chk("R10 ready stays low", req_ready, 0);
    chk("R10 no retry", req_retry, 0);
    step();
    unblock(1);
    chk("R8 retry after last cause", req_retry, 1);
    step();
    chk("R8 retry dropped", req_retry, 0);
  endtask

  task automatic t_evt_sat();
    for (int i = 0; i < 18; i++) begin
      block(1);
      unblock(1);
    end
    chk("R6 event saturation", evt(1), EMAX);
    chk("R6 expected saturation", evt(1), exp_evt[1]);
    chk("R7 write buffer cycles", cyc(1), exp_cyc[1]);
  endtask

  task automatic t_cyc_sat();
    block(0);
    repeat (300) step();
    unblock(0);
    chk("R7 cycle saturation", cyc(0), AMAX);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", edges);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_evt[0] = 0; exp_evt[1] = 0;
    exp_cyc[0] = 0; exp_cyc[1] = 0;
    t_set[0] = 0; t_set[1] = 0;
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_basic();
    t_no_alloc();
    t_sticky();
    t_reblock();
    t_retry();
    t_two();
    t_evt_sat();
    t_cyc_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule